// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block models a serial EEPROM that holds 64 words of 16 bits and is reached over a three-wire link. The link has a chip select, a serial clock and a data-in line. Results return on a data-out pin, which is presented to a pad as a value plus a drive enable. The block samples all three inputs into its own system clock domain and acts on each rising edge of the serial clock. Each transaction starts with a start bit, which is followed by an opcode and an address. The block supports word reads with address auto-increment, word writes, and commands that set and clear write permission.

A write runs a timed internal cycle. The cycle length is a count of system clocks, standing in for the programming time of a real part. While the cycle runs, the block ignores commands. After the host lowers and raises the chip select, the data-out pin shows whether the cycle is still running.

Top module: `uwire_eeprom`

## Requirements
- R1: DI is sampled on the rising edge of SK while CS is high. A command begins at the first DI=1 after CS rises, and any 0 bits before it are ignored.
- R2: Opcode bits 1,0 after the start bit select a read of the 6-bit address (MSB first). On the rise that takes the last address bit, DO presents one 0 dummy bit. Each later rise presents the next data bit, from bit 15 down to bit 0. The array holds all zeros after reset.
- R3: A read keeps streaming while CS stays high. After bit 0 of a word it continues with bit 15 of the next address, and address 63 wraps to 0.
- R4: Opcode bits 0,1 after the start bit, a 6-bit address and 16 data bits (MSB first) replace the whole addressed word, provided writes are permitted.
- R5: Write permission is off after reset, so a write sent before any enable command leaves the array unchanged.
- R6: Opcode 0,0 with the first two address bits 1,1 permits writes. Opcode 0,0 with the first two address bits 0,0 forbids them. The last four address bits of both commands are don't-care.
- R7: do_drive is 0 whenever CS is low. Lowering CS discards a partly received command, and the next command after that decodes normally.
- R8: An accepted write starts a busy period of WR_CYCLES system clocks. On the next rising edge of CS, DO is driven with 0 while the period lasts and with 1 after it ends. It stays driven until a start bit is accepted.
- R9: While a write cycle is busy, all DI bits are ignored. No command starts, and the status display stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select from the serial host |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| do_val | output | 1 | Value for the data-out pad |
| do_drive | output | 1 | Enable for the data-out pad; 0 means high impedance |

## Verification
Each SK rise is acted on three system clocks later: two synchroniser stages plus the edge register. DO therefore carries the bit for a rise well before the host lowers SK. The bench samples DO only after the SK pulse it sent has ended, and compares it with a behavioural word array, write-permission flag and busy flag. Status reads follow the CS rise by five clocks. Busy is checked early in a 600-clock cycle, and ready is checked after that window plus margin. The high-impedance rule for DO is compared on every falling clock edge while CS is low.

// File: rtl/uw_pkg.sv
package uw_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_OPC,
      ST_ADR,
      ST_WDAT,
      ST_READ,
      ST_DONE
   } uw_state_t;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] EXT_EN   = 2'b11;
   localparam logic [1:0] EXT_DIS  = 2'b00;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("uw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], d};
   end

   assign q    = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R1
   one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/uw_store.sv
module uw_store #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   // R4
   word_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/uw_busy_timer.sv
module uw_busy_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("uw_busy_timer: CYCLES must be positive");
      end
   endgenerate

   logic [TW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (start) begin
         busy <= 1'b1;
         left <= TW'(CYCLES - 1);
      end else if (busy) begin
         if (left == '0) busy <= 1'b0;
         else            left <= left - 1'b1;
      end
   end

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && left == '0 && !start) |=> !busy);
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uw_pkg::*;
#(
   parameter int AW          = 6,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WR_CYCLES   = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic do_val,
   output logic do_drive
);
   localparam int MAXW = (DW > AW) ? DW : AW;
   localparam int CW   = $clog2(MAXW);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("uwire_eeprom: AW must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("uwire_eeprom: DW must be at least 2");
      end
   endgenerate

   logic cs_s, cs_rise, sk_s, sk_rise, di_s, di_rise;

   uw_sync #(.STAGES(SYNC_STAGES)) u_cs (
      .clk(clk), .rst_n(rst_n), .d(cs), .q(cs_s), .rise(cs_rise));
   uw_sync #(.STAGES(SYNC_STAGES)) u_sk (
      .clk(clk), .rst_n(rst_n), .d(sk), .q(sk_s), .rise(sk_rise));
   uw_sync #(.STAGES(SYNC_STAGES)) u_di (
      .clk(clk), .rst_n(rst_n), .d(di), .q(di_s), .rise(di_rise));

   uw_state_t     st;
   logic [1:0]    op;
   logic [CW-1:0] cnt;
   logic [AW-1:0] adr_sr;
   logic [DW-1:0] dat_sr;
   logic [AW-1:0] rd_adr;
   logic [CW-1:0] rd_bit;
   logic          out_bit;
   logic          wen_q;
   logic          stat_arm;
   logic          stat_show;
   logic          arr_we;
   logic          busy;
   logic [DW-1:0] rdata;
   logic [AW-1:0] adr_full;
   logic          bit_tick;

   assign adr_full = {adr_sr[AW-2:0], di_s};
   assign bit_tick = sk_rise & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_HUNT;
         op        <= '0;
         cnt       <= '0;
         adr_sr    <= '0;
         dat_sr    <= '0;
         rd_adr    <= '0;
         rd_bit    <= '0;
         out_bit   <= 1'b0;
         wen_q     <= 1'b0;
         stat_arm  <= 1'b0;
         stat_show <= 1'b0;
         arr_we    <= 1'b0;
      end else begin
         arr_we <= 1'b0;
         if (cs_rise && stat_arm) stat_show <= 1'b1;
         if (!cs_s) begin
            st <= ST_HUNT;
         end else if (bit_tick) begin
            unique case (st)
               ST_HUNT: begin
                  if (di_s && !busy) begin
                     st        <= ST_OPC;
                     cnt       <= CW'(1);
                     stat_show <= 1'b0;
                     stat_arm  <= 1'b0;
                  end
               end
               ST_OPC: begin
                  op <= {op[0], di_s};
                  if (cnt == '0) begin
                     st  <= ST_ADR;
                     cnt <= CW'(AW - 1);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               ST_ADR: begin
                  adr_sr <= adr_full;
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else begin
                     unique case (op)
                        OP_READ: begin
                           st      <= ST_READ;
                           rd_adr  <= adr_full;
                           rd_bit  <= CW'(DW - 1);
                           out_bit <= 1'b0;
                        end
                        OP_WRITE: begin
                           st  <= ST_WDAT;
                           cnt <= CW'(DW - 1);
                        end
                        OP_EXT: begin
                           st <= ST_DONE;
                           if (adr_full[AW-1 -: 2] == EXT_EN)  wen_q <= 1'b1;
                           if (adr_full[AW-1 -: 2] == EXT_DIS) wen_q <= 1'b0;
                        end
                        default: st <= ST_DONE;
                     endcase
                  end
               end
               ST_WDAT: begin
                  dat_sr <= {dat_sr[DW-2:0], di_s};
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else begin
                     st <= ST_DONE;
                     if (wen_q) begin
                        arr_we   <= 1'b1;
                        stat_arm <= 1'b1;
                     end
                  end
               end
               ST_READ: begin
                  out_bit <= rdata[rd_bit];
                  if (rd_bit == '0) begin
                     rd_bit <= CW'(DW - 1);
                     rd_adr <= rd_adr + 1'b1;
                  end else begin
                     rd_bit <= rd_bit - 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   uw_store #(.AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(adr_sr),
      .wdata(dat_sr), .raddr(rd_adr), .rdata(rdata));

   uw_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(arr_we), .busy(busy));

   logic show_stat;
   assign show_stat = (st == ST_HUNT) && stat_show;

   always_comb begin
      do_val = 1'b0;
      if (st == ST_READ) do_val = out_bit;
      else if (show_stat) do_val = !busy;
   end

   assign do_drive = cs & ((st == ST_READ) | show_stat);

   // R7
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> st == ST_HUNT);

   // R5
   wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> wen_q);

   // R8
   stat_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      show_stat |-> do_val == !busy);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st == ST_HUNT) |=> st == ST_HUNT);
endmodule

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
   localparam int WRC = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic do_val, do_drive;

   int vectors = 0;
   int errors  = 0;
   int exp_mem [64];
   bit m_wen  = 1'b0;
   bit m_busy = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   uwire_eeprom #(.WR_CYCLES(WRC)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
      .do_val(do_val), .do_drive(do_drive));

   task automatic chk(input int act, input int expv, input string tag);
      vectors++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // R7: every clock with CS low the pad must not be driven
   always @(negedge clk) begin
      if (rst_n && !cs && !done) chk(int'(do_drive), 0, "R7 drive with cs low");
   end

   task automatic pulse(input bit b);
      di = b;
      repeat (3) @(negedge clk);
      sk = 1'b1;
      repeat (5) @(negedge clk);
      sk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send(input int val, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(val[i]);
   endtask

   task automatic cs_up();
      cs = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic cs_down();
      cs = 1'b0;
      di = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic rd(input int a, input int nw, input string tag);
      cs_up();
      send(3'b110, 3);
      send(a, 6);
      chk(int'(do_drive), 1, {tag, " drive"});
      chk(int'(do_val), 0, {tag, " dummy"});
      for (int w = 0; w < nw; w++) begin
         int word = 0;
         for (int b = 15; b >= 0; b--) begin
            pulse(1'b0);
            word = (word << 1) | int'(do_val);
         end
         chk(word, exp_mem[(a + w) % 64], tag);
      end
      cs_down();
   endtask

   task automatic wr(input int a, input int d);
      cs_up();
      send(3'b101, 3);
      send(a, 6);
      send(d, 16);
      if (m_wen && !m_busy) begin
         exp_mem[a] = d;
         m_busy = 1'b1;
      end
      cs_down();
   endtask

   task automatic ext(input int code6);
      cs_up();
      send(3'b100, 3);
      send(code6, 6);
      if (code6[5:4] == 2'b11) m_wen = 1'b1;
      if (code6[5:4] == 2'b00) m_wen = 1'b0;
      cs_down();
   endtask

   task automatic settle();
      repeat (WRC + 40) @(negedge clk);
      m_busy = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(int'(do_drive), 0, "R7 reset drive");

      // R2: read of reset array
      rd(5, 1, "R2 reset read");

      // R5: write before enable has no effect
      wr(3, 16'hA5A5);
      rd(3, 1, "R5 protected write");

      // R6: enable with don't-care bits 0101, then write
      ext(6'b110101);
      wr(3, 16'hA5A5);
      cs_up();
      chk(int'(do_drive), 1, "R8 status drive");
      chk(int'(do_val), 0, "R8 busy level");
      // R9: write stream during busy is ignored
      send(3'b101, 3);
      send(4, 6);
      send(16'hFFFF, 16);
      chk(int'(do_drive), 1, "R9 status kept");
      chk(int'(do_val), 0, "R9 still busy");
      repeat (WRC) @(negedge clk);
      chk(int'(do_val), 1, "R8 ready level");
      cs_down();
      m_busy = 1'b0;
      rd(3, 1, "R4 written word");
      rd(4, 1, "R9 busy write ignored");

      // R1: leading zeros before start bit
      cs_up();
      send(0, 3);
      send(3'b110, 3);
      send(3, 6);
      chk(int'(do_val), 0, "R1 dummy after zeros");
      begin
         int word = 0;
         for (int b = 15; b >= 0; b--) begin
            pulse(1'b0);
            word = (word << 1) | int'(do_val);
         end
         chk(word, exp_mem[3], "R1 read after zeros");
      end
      cs_down();

      // R3: auto increment across the top address
      wr(63, 16'h1234);
      settle();
      wr(0, 16'hBEEF);
      settle();
      rd(62, 4, "R3 stream wrap");

      // R7: aborted partial write
      cs_up();
      send(3'b101, 3);
      send(3, 6);
      send(16'h00, 8);
      cs_down();
      rd(3, 1, "R7 abort keeps word");

      // R6: disable with don't-care bits 1010, write ignored
      ext(6'b001010);
      wr(3, 16'h0000);
      rd(3, 1, "R6 disabled write");

      // R4: re-enable with don't-care 0000, overwrite
      ext(6'b110000);
      wr(10, 16'h8001);
      settle();
      rd(10, 1, "R4 second word");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule